// File: doc/BRIEF.md
# Buffered Asynchronous Serial Channel with Receive Flow Control

This block is one full-duplex asynchronous serial channel that sends and receives characters of one start bit, eight data bits least significant bit first, and one stop bit, with no parity. Its timing comes from a single-cycle sample tick supplied by the surrounding logic, not from the system clock. A 16-bit divisor input gives the number of ticks in one bit period. Each direction has its own 16-entry byte queue. The host pushes bytes for transmission through a valid/ready stream and pops received bytes through a second valid/ready stream.

The transmitter changes its line level only on bit-period boundaries. When it is idle at such a boundary and its queue holds a byte, it removes the byte and starts a frame. The receiver waits for a low level on the idle line. It takes its first sample one and a half bit periods later and then one sample per bit period. The ninth sample is the stop bit, and it closes the frame. Two ready-to-receive outputs, which always carry the same value, follow the space left in the receive queue. A byte that would take the last free slot is discarded. When that happens, the ready outputs drop and a sticky overrun flag is set. Popping a byte raises the ready outputs again.

Back-pressure rules: a push is taken on a clock where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low while 16 bytes wait. A pop happens on a clock where `rx_valid` and `rx_ready` are both high. `rx_valid` stays high and `rx_data` stays stable until that pop.

Top module: `uart_flow_channel`

## Requirements
- R1: `txd` is high in reset and when idle. A frame is a low start bit, then data bits 0 to 7, then a high stop bit. Each bit lasts `bit_div` ticks, so one character takes 10 bit periods.
- R2: A tick counter sets the transmit bit-period boundaries. `txd` changes only on a boundary. At a boundary, an idle transmitter with a non-empty queue removes the oldest byte and drives its start bit.
- R3: The transmit queue holds 16 bytes in arrival order. `tx_ready` is low while 16 bytes are stored, and a push offered while `tx_ready` is low has no effect.
- R4: The receiver starts a frame on a tick where the line is low while it is idle. Its first sample comes `bit_div + floor(bit_div/2)` ticks later, which is 36 ticks for a divisor of 24. Each following sample comes `bit_div` ticks after the one before. The first 8 samples form the byte, least significant bit first, and the 9th sample ends the frame.
- R5: Received bytes come out in arrival order. `rx_valid` is high while the receive queue is non-empty, `rx_data` shows the oldest byte, and a pop removes it.
- R6: If a frame ends while 15 bytes are stored, the byte is discarded, `cts` and `dsr` go low, and `overrun` goes high. `overrun` stays high until reset.
- R7: Storing a received byte, or popping one, drives `cts` and `dsr` high. A pop takes priority over a discard in the same clock.
- R8: While `enable` is low, the receiver ignores the line and leaves any frame in progress. The transmitter holds its state and starts no frame.
- R9: After reset, `txd`, `tx_ready`, `cts` and `dsr` are high, and `rx_valid` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Channel enable |
| tick | input | 1 | Single-cycle sample tick |
| bit_div | input | 16 | Ticks per bit period |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit queue can accept a byte |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Oldest received byte |
| rx_ready | input | 1 | Host pops the received byte |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts | output | 1 | Ready to receive, clear-to-send sense |
| dsr | output | 1 | Ready to receive, data-set-ready sense |
| overrun | output | 1 | Sticky receive overrun flag |

## Verification
The hardest state to reach is the overrun boundary. The receive queue must already hold exactly 15 bytes when a frame completes, and then one more byte must be popped. To get there, the stimulus sends sixteen back-to-back serial frames with `rx_ready` held low. It checks that the ready outputs are still high after the fifteenth frame and low after the sixteenth. It then drains the queue to confirm that the sixteenth byte is absent and that the first pop raises the ready outputs again. For transmission, a behavioural queue-and-counter model is compared with the line on every clock while the queue is filled past capacity and a refused push is offered.

// File: rtl/uart_chan_pkg.sv
package uart_chan_pkg;
  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_FRAME = 1'b1
  } rx_state_e;

  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/uart_ring.sv
module uart_ring #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = uart_chan_pkg::bits_for(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic              do_wr, do_rd;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rd_ptr];

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_nxt;
      if (do_rd) rd_ptr <= rd_nxt;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  localparam int LEFT_W = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic [DIV_W-1:0]  bit_div,
  input  logic              have_data,
  input  logic [DATA_W-1:0] data_in,
  output logic              pop,
  output logic              txd
);
  logic [DIV_W-1:0]  tcnt;
  logic [DATA_W:0]   shreg;
  logic [LEFT_W-1:0] left;
  logic              boundary;

  assign boundary = en && tick && (({1'b0, tcnt} + 1'b1) >= {1'b0, bit_div});
  assign pop      = boundary && (left == '0) && have_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt  <= '0;
      shreg <= '0;
      left  <= '0;
      txd   <= 1'b1;
    end else begin
      if (en && tick) tcnt <= boundary ? '0 : tcnt + 1'b1;
      if (pop) begin
        txd   <= 1'b0;
        shreg <= {1'b1, data_in};
        left  <= LEFT_W'(DATA_W + 1);
      end else if (boundary && (left != '0)) begin
        txd   <= shreg[0];
        shreg <= shreg >> 1;
        left  <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  localparam int SMP_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic [DIV_W-1:0]  bit_div,
  input  logic              line,
  output logic              done,
  output logic [DATA_W-1:0] byte_out,
  output logic              busy
);
  import uart_chan_pkg::*;

  rx_state_e         state;
  logic [DIV_W:0]    wait_cnt;
  logic [SMP_W-1:0]  samples;
  logic [DATA_W-1:0] shreg;
  logic [DIV_W:0]    first_wait;

  assign first_wait = {1'b0, bit_div} + ({1'b0, bit_div} >> 1);
  assign busy       = (state == RX_FRAME);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      wait_cnt <= '0;
      samples  <= '0;
      shreg    <= '0;
      done     <= 1'b0;
      byte_out <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
      end else if (tick) begin
        if (state == RX_IDLE) begin
          if (!line) begin
            state    <= RX_FRAME;
            wait_cnt <= first_wait;
            samples  <= '0;
          end
        end else if (wait_cnt <= 1) begin
          wait_cnt <= {1'b0, bit_div};
          if (samples == SMP_W'(DATA_W)) begin
            state    <= RX_IDLE;
            done     <= 1'b1;
            byte_out <= shreg;
          end else begin
            shreg   <= {line, shreg[DATA_W-1:1]};
            samples <= samples + 1'b1;
          end
        end else begin
          wait_cnt <= wait_cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_done,
  input  logic [CNT_W-1:0] occupancy,
  input  logic             popped,
  output logic             store,
  output logic             cts,
  output logic             dsr,
  output logic             overrun
);
  logic drop;

  assign drop  = frame_done && ((occupancy + 1'b1) == CNT_W'(DEPTH));
  assign store = frame_done && !drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts     <= 1'b1;
      dsr     <= 1'b1;
      overrun <= 1'b0;
    end else begin
      if (popped || store) begin
        cts <= 1'b1;
        dsr <= 1'b1;
      end else if (drop) begin
        cts <= 1'b0;
        dsr <= 1'b0;
      end
      if (drop) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_flow_channel.sv
module uart_flow_channel #(
  parameter int DEPTH  = 16,
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              tick,
  input  logic [DIV_W-1:0]  bit_div,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  input  logic              rx_ready,
  input  logic              rxd,
  output logic              txd,
  output logic              cts,
  output logic              dsr,
  output logic              overrun
);
  logic [CNT_W-1:0]  tx_count, rx_count;
  logic              tx_full, tx_empty, tx_pop;
  logic [DATA_W-1:0] tx_head;
  logic              rx_full, rx_empty, rx_pop, rx_store, rx_done, rx_busy;
  logic [DATA_W-1:0] rx_byte;
  logic              rxd_meta, rxd_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd_meta <= 1'b1;
      rxd_sync <= 1'b1;
    end else begin
      rxd_meta <= rxd;
      rxd_sync <= rxd_meta;
    end
  end

  assign tx_ready = !tx_full;
  assign rx_valid = !rx_empty;
  assign rx_pop   = rx_valid && rx_ready;

  uart_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx_ring (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tx_valid), .wr_data(tx_data),
    .rd_en(tx_pop), .rd_data(tx_head),
    .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  uart_tx_ser #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(enable), .tick(tick), .bit_div(bit_div),
    .have_data(!tx_empty), .data_in(tx_head), .pop(tx_pop), .txd(txd)
  );

  uart_rx_deser #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(enable), .tick(tick), .bit_div(bit_div),
    .line(rxd_sync), .done(rx_done), .byte_out(rx_byte), .busy(rx_busy)
  );

  uart_flow_ctl #(.DEPTH(DEPTH)) u_flow (
    .clk(clk), .rst_n(rst_n), .frame_done(rx_done), .occupancy(rx_count),
    .popped(rx_pop), .store(rx_store), .cts(cts), .dsr(dsr), .overrun(overrun)
  );

  uart_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx_ring (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rx_store), .wr_data(rx_byte),
    .rd_en(rx_pop), .rd_data(rx_data),
    .count(rx_count), .full(rx_full), .empty(rx_empty)
  );
endmodule

// File: rtl/uart_chan_checker.sv
module uart_chan_checker #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             tx_ready,
  input logic [CNT_W-1:0] tx_cnt,
  input logic             tx_pop,
  input logic             txd,
  input logic [CNT_W-1:0] rx_cnt,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic             rx_busy,
  input logic             cts,
  input logic             dsr,
  input logic             overrun
);
  // R3: a refused push must not grow the queue
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |=> tx_cnt <= $past(tx_cnt));

  // R2: removing a byte launches its start bit
  p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !txd);

  // R6: receive queue never passes one short of capacity
  p_rx_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CNT_W'(DEPTH - 1));

  // R6: overrun is sticky
  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R7: a pop reasserts both ready outputs
  p_pop_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> (cts && dsr));

  // R5: an unpopped byte stays visible
  p_hold_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  // R8: disabling the channel abandons reception
  p_disable_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !rx_busy);
endmodule

bind uart_flow_channel uart_chan_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .tx_ready(tx_ready), .tx_cnt(tx_count), .tx_pop(tx_pop), .txd(txd),
  .rx_cnt(rx_count), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_busy(rx_busy),
  .cts(cts), .dsr(dsr), .overrun(overrun)
);

// File: tb/tb_uart_flow_channel.sv
`timescale 1ns/1ps
module tb_uart_flow_channel;
  localparam int TPER = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        tick = 1'b0;
  logic [15:0] bit_div = 16'd8;
  logic        tx_valid = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_ready, rx_valid, txd, cts, dsr, overrun;
  logic [7:0]  rx_data;
  logic        rx_ready = 1'b0;
  logic        rxd = 1'b1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int tphase = 0;
  bit started = 0;

  uart_flow_channel dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .bit_div(bit_div),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .rxd(rxd), .txd(txd), .cts(cts), .dsr(dsr), .overrun(overrun)
  );

  always #2 clk = ~clk;

  // tick generator
  always @(negedge clk) begin
    tphase <= (tphase == TPER - 1) ? 0 : tphase + 1;
    tick   <= (tphase == TPER - 1);
  end

  // behavioural transmit model
  logic [7:0] mq[$];
  int         m_cnt = 0, m_left = 0;
  logic [8:0] m_sh = '0;
  logic       m_txd = 1'b1;
  bit         m_room;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_left = 0; m_sh = '0; m_txd = 1'b1; mq.delete();
    end else begin
      m_room = (mq.size() < 16);
      if (enable && tick) begin
        if (m_cnt + 1 >= int'(bit_div)) begin
          m_cnt = 0;
          if (m_left == 0) begin
            if (mq.size() > 0) begin
              m_sh = {1'b1, mq.pop_front()};
              m_txd = 1'b0;
              m_left = 9;
            end
          end else begin
            m_txd = m_sh[0];
            m_sh = m_sh >> 1;
            m_left--;
          end
        end else m_cnt++;
      end
      if (tx_valid && m_room) mq.push_back(tx_data);
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  // per-clock comparison
  always @(negedge clk) begin
    cycles++;
    if (rst_n && started) begin
      check(txd == m_txd, "R1 R2 txd vs model", txd, m_txd);
      check(tx_ready == (mq.size() < 16), "R3 tx_ready vs model", tx_ready, mq.size() < 16);
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = b;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic drain_tx();
    while (mq.size() != 0 || m_left != 0) @(negedge clk);
    repeat (int'(bit_div) * TPER * 2) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] b);
    int bc;
    bc = int'(bit_div) * TPER;
    @(negedge clk);
    rxd = 1'b0;
    repeat (bc) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (bc) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (2 * bc) @(negedge clk);
  endtask

  task automatic pop_rx(input logic [7:0] exp, input string what);
    @(negedge clk);
    check(rx_valid == 1'b1, {what, " rx_valid"}, rx_valid, 1);
    check(rx_data == exp, {what, " rx_data"}, rx_data, exp);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    check(txd == 1'b1, "R9 txd", txd, 1);
    check(tx_ready == 1'b1, "R9 tx_ready", tx_ready, 1);
    check(rx_valid == 1'b0, "R9 rx_valid", rx_valid, 0);
    check(cts == 1'b1 && dsr == 1'b1, "R9 cts/dsr", {cts, dsr}, 3);
    check(overrun == 1'b0, "R9 overrun", overrun, 0);
    rst_n = 1'b1;
    started = 1;
    repeat (5) @(negedge clk);

    // R1 R2: a few characters, model compared every clock
    push_tx(8'hA5);
    push_tx(8'h01);
    push_tx(8'h80);
    drain_tx();

    // R3: fill beyond capacity, then offer a refused push
    for (int i = 0; i < 17; i++) push_tx(8'(8'h10 + i));
    @(negedge clk);
    while (tx_ready) @(negedge clk);
    check(tx_ready == 1'b0, "R3 tx_ready low when full", tx_ready, 0);
    tx_valid = 1'b1; tx_data = 8'hEE;
    @(negedge clk);
    tx_valid = 1'b0;
    push_tx(8'h5A);
    drain_tx();
    check(txd == 1'b1, "R1 idle line high", txd, 1);

    // R4 R5: receive with divisor 8
    send_rx(8'hA5);
    send_rx(8'h3C);
    pop_rx(8'hA5, "R4 R5 first byte");
    pop_rx(8'h3C, "R4 R5 second byte");
    @(negedge clk);
    check(rx_valid == 1'b0, "R5 empty after pops", rx_valid, 0);

    // R4: divisor 24, first sample at 36 ticks
    bit_div = 16'd24;
    repeat (10) @(negedge clk);
    send_rx(8'hC3);
    pop_rx(8'hC3, "R4 divisor 24");
    push_tx(8'h96);
    drain_tx();
    bit_div = 16'd8;
    repeat (200) @(negedge clk);

    // R6 R7: fill the receive queue to the discard point
    for (int i = 0; i < 15; i++) send_rx(8'(8'h40 + i));
    check(cts == 1'b1 && dsr == 1'b1, "R7 ready after 15th store", {cts, dsr}, 3);
    check(overrun == 1'b0, "R6 no overrun at 15", overrun, 0);
    send_rx(8'hFF);
    check(cts == 1'b0 && dsr == 1'b0, "R6 ready dropped", {cts, dsr}, 0);
    check(overrun == 1'b1, "R6 overrun set", overrun, 1);
    pop_rx(8'h40, "R5 R6 head after overrun");
    @(negedge clk);
    check(cts == 1'b1 && dsr == 1'b1, "R7 pop raises ready", {cts, dsr}, 3);
    for (int i = 1; i < 15; i++) pop_rx(8'(8'h40 + i), "R5 drain order");
    @(negedge clk);
    check(rx_valid == 1'b0, "R6 discarded byte absent", rx_valid, 0);
    check(overrun == 1'b1, "R6 overrun sticky", overrun, 1);

    // R8: disabled channel
    enable = 1'b0;
    send_rx(8'h55);
    @(negedge clk);
    check(rx_valid == 1'b0, "R8 line ignored when disabled", rx_valid, 0);
    push_tx(8'h81);
    repeat (400) @(negedge clk);
    check(txd == 1'b1, "R8 no frame when disabled", txd, 1);
    enable = 1'b1;
    drain_tx();
    send_rx(8'h7E);
    pop_rx(8'h7E, "R8 receive after re-enable");

    repeat (20) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule